// File: doc/BRIEF.md
# Slot-scheduled sample memory host port

This block sits between a synthesis engine, its sample memory and a host register port. The memory is single-ported and is driven only from here. Time is divided into voice slots, announced by a slot number and a one-cycle slot strobe. Each slot carries a flag that gives it either to synthesis or to the host. In synthesis slots the engine's fetch passes straight through to the memory. The host can reach memory only in slots flagged for it, so host traffic never takes a synthesis slot.

The host sees four registers: a left pointer, a right pointer, a left data register and a right data register. To stream writes, software loads a pointer once and then writes data words. Each word goes into a small FIFO together with the pointer value at the time of the write, and the pointer steps by one. To stream reads, software loads a pointer. The word at that address is then fetched into the data register during a later host slot, and a valid flag goes up. Consuming the word advances the pointer and starts the next fetch. The left and right sides keep separate pointers and separate read state.

The memory has a one-cycle read latency. Data requested in the slot-strobe cycle is present on `mem_rdata_i` in the following cycle.

Top module: `smem_host_port`

## Requirements
- R1: While reset is asserted and immediately after it, `host_busy_o` is 0, `host_valid_o` is 0 and both pointers read back as 0.
- R2: In a strobe cycle of a slot whose flag bit is 0, the memory port carries the engine request: `mem_req_o` equals `syn_req_i`, `mem_addr_o` equals `syn_addr_i` and `mem_we_o` is 0.
- R3: `mem_req_o` is 0 in every cycle where `slot_tick_i` is 0. A host access happens only in the strobe cycle of a slot whose bit in `host_slot_mask_i` is 1, and there is at most one access per slot.
- R4: The `host_reg_i` codes are: 2'b00 left pointer, 2'b01 right pointer, 2'b10 left data, 2'b11 right data. Reading a pointer code returns that pointer on `host_rdata_o`, and writing it loads the pointer.
- R5: A data-register write that is accepted queues {pointer, word} and increments that side's pointer by 1. Queued words are written to memory in the order they were accepted.
- R6: `host_busy_o` is 1 while the FIFO holds FIFO_DEPTH entries. A data write made while it is 1 is dropped: the pointer does not change and nothing reaches memory.
- R7: In a host slot, a queued write is served before any read fetch. Among fetches, left is served before right.
- R8: After a pointer load, the word at the pointer is fetched in a later host slot. `host_valid_o` for that side rises two cycles after the request cycle, and `host_rdata_o` (data code) then shows the word.
- R9: A data-register read while valid clears valid, increments the pointer by 1 and starts a fetch of the next word.
- R10: A data-register read while that side is not valid is ignored, and the pointer does not change.
- R11: A pointer load clears that side's valid flag on the next cycle and discards any fetch already in flight.
- R12: The left and right pointers and their read states are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host data-register read strobe (consumes the word) |
| host_reg_i | input | 2 | Register select |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Selected register contents |
| host_busy_o | output | 1 | Write FIFO full |
| host_valid_o | output | 2 | Read word valid, bit 0 left, bit 1 right |
| slot_i | input | SLOT_W | Current voice slot |
| slot_tick_i | input | 1 | One-cycle strobe at the start of each slot |
| host_slot_mask_i | input | NUM_SLOTS | Per-slot flag, 1 marks a host slot |
| syn_req_i | input | 1 | Engine fetch request |
| syn_addr_i | input | ADDR_W | Engine fetch address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after the request |

## Verification
The assertions check these properties on every cycle:
- synthesis-slot passthrough, and the absence of requests outside slot strobes;
- write-before-fetch priority;
- the pointer step after an accepted write, and the frozen pointers after a dropped write;
- the cleared valid flag after a pointer load;
- the two-cycle link between a host read request and a rising valid flag.

Only the bench scenarios can show the rest. They show that each queued word reaches the right address in order, and that streamed reads return the data just written. They also show that a fetch aimed at an address still in the FIFO waits for that write, that left wins over right, and that an early read strobe leaves the pointer untouched.

// File: rtl/smem_pkg.sv
`timescale 1ns/1ps
package smem_pkg;

  typedef enum logic [1:0] {
    REG_PTR_L = 2'b00,
    REG_PTR_R = 2'b01,
    REG_DAT_L = 2'b10,
    REG_DAT_R = 2'b11
  } hreg_e;

  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_WR   = 2'd1,
    GNT_RD_L = 2'd2,
    GNT_RD_R = 2'd3
  } gnt_e;

  localparam int NUM_CHAN = 2;

endpackage

// File: rtl/smem_wfifo.sv
`timescale 1ns/1ps
module smem_wfifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);

  logic [W-1:0]  store_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = store_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) store_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= wp_q + AW'(1);
      if (pop_ok)  rp_q <= rp_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/smem_chan.sv
`timescale 1ns/1ps
module smem_chan #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_wr_i,
  input  logic [ADDR_W-1:0] ptr_wdata_i,
  input  logic              dat_wr_i,
  input  logic              dat_rd_i,
  input  logic              fetch_gnt_i,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              need_o,
  output logic              vld_o,
  output logic [DATA_W-1:0] dreg_o
);

  logic [ADDR_W-1:0] ptr_q;
  logic              need_q, vld_q;
  logic [DATA_W-1:0] dreg_q;
  logic              consume;

  assign consume = dat_rd_i && vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      need_q <= 1'b0;
      vld_q  <= 1'b0;
      dreg_q <= '0;
    end else begin
      if (ptr_wr_i)                 ptr_q <= ptr_wdata_i;
      else if (dat_wr_i || consume) ptr_q <= ptr_q + ADDR_W'(1);

      if (ptr_wr_i || consume) need_q <= 1'b1;
      else if (dat_wr_i)       need_q <= 1'b0;
      else if (fetch_gnt_i)    need_q <= 1'b0;

      if (ptr_wr_i || dat_wr_i || consume) vld_q <= 1'b0;
      else if (fill_i)                     vld_q <= 1'b1;

      if (fill_i) dreg_q <= fill_data_i;
    end
  end

  assign ptr_o  = ptr_q;
  assign need_o = need_q;
  assign vld_o  = vld_q;
  assign dreg_o = dreg_q;

endmodule

// File: rtl/smem_slot_arb.sv
`timescale 1ns/1ps
module smem_slot_arb
  import smem_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [SLOT_W-1:0]             slot_i,
  input  logic                          tick_i,
  input  logic [NUM_SLOTS-1:0]          mask_i,
  input  logic                          wq_empty_i,
  input  logic [NUM_CHAN-1:0]           need_i,
  input  logic [ADDR_W-1:0]             wq_addr_i,
  input  logic [DATA_W-1:0]             wq_data_i,
  input  logic [NUM_CHAN-1:0][ADDR_W-1:0] ptr_i,
  input  logic                          syn_req_i,
  input  logic [ADDR_W-1:0]             syn_addr_i,
  output gnt_e                          gnt_o,
  output logic                          mem_req_o,
  output logic                          mem_we_o,
  output logic [ADDR_W-1:0]             mem_addr_o,
  output logic [DATA_W-1:0]             mem_wdata_o
);

  logic host_slot;

  assign host_slot = mask_i[slot_i];

  // writes drain first so a fetch never sees stale data
  always_comb begin
    gnt_o = GNT_NONE;
    if (tick_i && host_slot) begin
      if (!wq_empty_i)    gnt_o = GNT_WR;
      else if (need_i[0]) gnt_o = GNT_RD_L;
      else if (need_i[1]) gnt_o = GNT_RD_R;
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (tick_i && !host_slot) begin
      mem_req_o  = syn_req_i;
      mem_addr_o = syn_addr_i;
    end else begin
      case (gnt_o)
        GNT_WR: begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = wq_addr_i;
          mem_wdata_o = wq_data_i;
        end
        GNT_RD_L: begin
          mem_req_o  = 1'b1;
          mem_addr_o = ptr_i[0];
        end
        GNT_RD_R: begin
          mem_req_o  = 1'b1;
          mem_addr_o = ptr_i[1];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/smem_host_port.sv
`timescale 1ns/1ps
module smem_host_port
  import smem_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 host_wr_i,
  input  logic                 host_rd_i,
  input  logic [1:0]           host_reg_i,
  input  logic [DATA_W-1:0]    host_wdata_i,
  output logic [DATA_W-1:0]    host_rdata_o,
  output logic                 host_busy_o,
  output logic [1:0]           host_valid_o,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic                 slot_tick_i,
  input  logic [NUM_SLOTS-1:0] host_slot_mask_i,
  input  logic                 syn_req_i,
  input  logic [ADDR_W-1:0]    syn_addr_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic [DATA_W-1:0]    mem_rdata_i
);

  localparam int ENT_W = ADDR_W + DATA_W;

  logic                           sel_ch, is_dat;
  logic [NUM_CHAN-1:0]            ptr_wr, dat_wr, dat_rd, kill, need, fill, fetch_gnt;
  logic [NUM_CHAN-1:0][ADDR_W-1:0] chan_ptr;
  logic [NUM_CHAN-1:0][DATA_W-1:0] dreg;
  logic                           wq_full, wq_empty;
  logic [ENT_W-1:0]               wq_head;
  gnt_e                           gnt;
  logic                           rd_gnt, gnt_ch;
  logic                           infl_v_q, infl_ch_q;

  assign sel_ch = host_reg_i[0];
  assign is_dat = host_reg_i[1];
  assign rd_gnt = (gnt == GNT_RD_L) || (gnt == GNT_RD_R);
  assign gnt_ch = (gnt == GNT_RD_R);

  always_comb begin
    for (int c = 0; c < NUM_CHAN; c++) begin
      ptr_wr[c]    = host_wr_i && !is_dat && (sel_ch == 1'(c));
      dat_wr[c]    = host_wr_i && is_dat && (sel_ch == 1'(c)) && !wq_full;
      dat_rd[c]    = host_rd_i && !host_wr_i && is_dat && (sel_ch == 1'(c));
      kill[c]      = ptr_wr[c] || dat_wr[c];
      fetch_gnt[c] = rd_gnt && (gnt_ch == 1'(c));
      fill[c]      = infl_v_q && (infl_ch_q == 1'(c)) && !kill[c];
    end
  end

  // one read in flight at most; a pointer move during it discards the result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      infl_v_q  <= 1'b0;
      infl_ch_q <= 1'b0;
    end else begin
      infl_v_q  <= rd_gnt && !kill[gnt_ch];
      infl_ch_q <= gnt_ch;
    end
  end

  smem_wfifo #(
    .W     (ENT_W),
    .DEPTH (FIFO_DEPTH)
  ) u_wfifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (|dat_wr),
    .din_i   ({chan_ptr[sel_ch], host_wdata_i}),
    .pop_i   (gnt == GNT_WR),
    .dout_o  (wq_head),
    .empty_o (wq_empty),
    .full_o  (wq_full)
  );

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    smem_chan #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ptr_wr_i    (ptr_wr[c]),
      .ptr_wdata_i (ADDR_W'(host_wdata_i)),
      .dat_wr_i    (dat_wr[c]),
      .dat_rd_i    (dat_rd[c]),
      .fetch_gnt_i (fetch_gnt[c]),
      .fill_i      (fill[c]),
      .fill_data_i (mem_rdata_i),
      .ptr_o       (chan_ptr[c]),
      .need_o      (need[c]),
      .vld_o       (host_valid_o[c]),
      .dreg_o      (dreg[c])
    );
  end

  smem_slot_arb #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_arb (
    .slot_i      (slot_i),
    .tick_i      (slot_tick_i),
    .mask_i      (host_slot_mask_i),
    .wq_empty_i  (wq_empty),
    .need_i      (need),
    .wq_addr_i   (wq_head[ENT_W-1:DATA_W]),
    .wq_data_i   (wq_head[DATA_W-1:0]),
    .ptr_i       (chan_ptr),
    .syn_req_i   (syn_req_i),
    .syn_addr_i  (syn_addr_i),
    .gnt_o       (gnt),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign host_busy_o  = wq_full;
  assign host_rdata_o = is_dat ? dreg[sel_ch] : DATA_W'(chan_ptr[sel_ch]);

endmodule

// File: rtl/smem_host_port_chk.sv
`timescale 1ns/1ps
module smem_host_port_chk #(
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [SLOT_W-1:0]      slot_i,
  input logic                   slot_tick_i,
  input logic [NUM_SLOTS-1:0]   host_slot_mask_i,
  input logic                   syn_req_i,
  input logic [ADDR_W-1:0]      syn_addr_i,
  input logic                   host_wr_i,
  input logic [1:0]             host_reg_i,
  input logic                   host_busy_o,
  input logic [1:0]             host_valid_o,
  input logic                   mem_req_o,
  input logic                   mem_we_o,
  input logic [ADDR_W-1:0]      mem_addr_o,
  input logic                   wq_empty,
  input logic [1:0][ADDR_W-1:0] chan_ptr
);

  logic hs;
  assign hs = host_slot_mask_i[slot_i];

  // R2
  syn_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_tick_i && !hs) |-> (mem_req_o == syn_req_i && !mem_we_o && mem_addr_o == syn_addr_i));

  // R3
  no_stray_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_tick_i |-> !mem_req_o);

  // R5
  ptr_step_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_reg_i == 2'b10 && !host_busy_o) |=> chan_ptr[0] == $past(chan_ptr[0]) + ADDR_W'(1));

  // R5
  ptr_step_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_reg_i == 2'b11 && !host_busy_o) |=> chan_ptr[1] == $past(chan_ptr[1]) + ADDR_W'(1));

  // R6
  drop_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_reg_i[1] && host_busy_o) |=> chan_ptr == $past(chan_ptr));

  // R7
  write_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_tick_i && hs && !wq_empty) |-> (mem_req_o && mem_we_o));

  // R8
  valid_after_fetch_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_valid_o[0]) |-> $past(slot_tick_i && hs && mem_req_o && !mem_we_o && mem_addr_o == chan_ptr[0], 2));

  // R8
  valid_after_fetch_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_valid_o[1]) |-> $past(slot_tick_i && hs && mem_req_o && !mem_we_o && mem_addr_o == chan_ptr[1], 2));

  // R11
  ptr_load_clears_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_reg_i == 2'b00) |=> !host_valid_o[0]);

  // R11
  ptr_load_clears_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_reg_i == 2'b01) |=> !host_valid_o[1]);

endmodule

bind smem_host_port smem_host_port_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .slot_i           (slot_i),
  .slot_tick_i      (slot_tick_i),
  .host_slot_mask_i (host_slot_mask_i),
  .syn_req_i        (syn_req_i),
  .syn_addr_i       (syn_addr_i),
  .host_wr_i        (host_wr_i),
  .host_reg_i       (host_reg_i),
  .host_busy_o      (host_busy_o),
  .host_valid_o     (host_valid_o),
  .mem_req_o        (mem_req_o),
  .mem_we_o         (mem_we_o),
  .mem_addr_o       (mem_addr_o),
  .wq_empty         (wq_empty),
  .chan_ptr         (chan_ptr)
);

// File: tb/tb_smem_host_port.sv
`timescale 1ns/1ps
module tb_smem_host_port;

  localparam int NUM_SLOTS = 32;
  localparam int SLOT_W    = 5;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 16;
  localparam logic [NUM_SLOTS-1:0] HOST_MASK = 32'h2020_2020;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              host_wr_i = 1'b0, host_rd_i = 1'b0;
  logic [1:0]        host_reg_i = 2'b00;
  logic [DATA_W-1:0] host_wdata_i = '0;
  logic [DATA_W-1:0] host_rdata_o;
  logic              host_busy_o;
  logic [1:0]        host_valid_o;
  logic [SLOT_W-1:0] slot = '0;
  logic              slot_tick = 1'b0;
  logic              syn_req;
  logic [ADDR_W-1:0] syn_addr;
  logic              mem_req_o, mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W-1:0] mem_wdata_o;
  logic [DATA_W-1:0] mem_rdata = '0;

  logic [DATA_W-1:0] mem    [256];
  logic [DATA_W-1:0] shadow [256];
  logic [ADDR_W-1:0] ptrm   [2];
  logic [31:0]       exp_q  [$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign syn_req  = 1'b1;
  assign syn_addr = 16'hF000 | ADDR_W'(slot);

  smem_host_port dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_wr_i(host_wr_i), .host_rd_i(host_rd_i), .host_reg_i(host_reg_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .host_busy_o(host_busy_o), .host_valid_o(host_valid_o),
    .slot_i(slot), .slot_tick_i(slot_tick), .host_slot_mask_i(HOST_MASK),
    .syn_req_i(syn_req), .syn_addr_i(syn_addr),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model, one-cycle read latency
  initial for (int i = 0; i < 256; i++) begin
    mem[i]    <= 16'hC000 + 16'(i);
    shadow[i] =  16'hC000 + 16'(i);
  end

  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
      else          mem_rdata <= mem[mem_addr_o[7:0]];
    end
  end

  // slot sequencer: 4 cycles per slot
  initial begin
    logic [1:0] ph = 2'd0;
    forever begin
      @(posedge clk); #1;
      ph = ph + 2'd1;
      if (ph == 2'd0) slot = slot + 1'b1;
      slot_tick = (ph == 2'd0);
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (slot_tick && !HOST_MASK[slot])
        chk(mem_req_o == syn_req && !mem_we_o && mem_addr_o == syn_addr,
            "R2 synthesis slot passthrough", {14'd0, mem_req_o, mem_we_o, mem_addr_o},
            {14'd0, syn_req, 1'b0, syn_addr});
      else if (!slot_tick)
        chk(!mem_req_o, "R3 request outside slot strobe", 32'(mem_req_o), 32'd0);
      if (slot_tick && HOST_MASK[slot] && mem_req_o && mem_we_o) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R6 unexpected memory write", {mem_addr_o, mem_wdata_o}, 32'd0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk({mem_addr_o, mem_wdata_o} == e, "R5 write address/order", {mem_addr_o, mem_wdata_o}, e);
        end
      end
    end
  end

  task automatic wait_host_slot();
    @(negedge clk);
    while (!(slot_tick && HOST_MASK[slot])) @(negedge clk);
  endtask

  task automatic set_ptr(input int ch, input logic [ADDR_W-1:0] a);
    @(posedge clk); #1;
    host_wr_i = 1'b1; host_reg_i = {1'b0, 1'(ch)}; host_wdata_i = a;
    ptrm[ch] = a;
    @(posedge clk); #1;
    host_wr_i = 1'b0;
  endtask

  task automatic write_word(input int ch, input logic [DATA_W-1:0] d);
    @(negedge clk);
    while (host_busy_o) @(negedge clk);
    @(posedge clk); #1;
    host_wr_i = 1'b1; host_reg_i = {1'b1, 1'(ch)}; host_wdata_i = d;
    exp_q.push_back({ptrm[ch], d});
    shadow[ptrm[ch][7:0]] = d;
    ptrm[ch] = ptrm[ch] + 1'b1;
    @(posedge clk); #1;
    host_wr_i = 1'b0;
  endtask

  task automatic write_drop(input int ch, input logic [DATA_W-1:0] d);
    @(posedge clk); #1;
    host_wr_i = 1'b1; host_reg_i = {1'b1, 1'(ch)}; host_wdata_i = d;
    @(negedge clk);
    chk(host_busy_o, "R6 busy during dropped write", 32'(host_busy_o), 32'd1);
    @(posedge clk); #1;
    host_wr_i = 1'b0;
  endtask

  task automatic chk_ptr(input int ch, input string tag);
    @(posedge clk); #1;
    host_reg_i = {1'b0, 1'(ch)};
    @(negedge clk);
    chk(host_rdata_o == DATA_W'(ptrm[ch]), tag, 32'(host_rdata_o), 32'(ptrm[ch]));
  endtask

  task automatic read_word(input int ch, input string tag);
    logic [DATA_W-1:0] e;
    @(posedge clk); #1;
    host_reg_i = {1'b1, 1'(ch)};
    @(negedge clk);
    while (!host_valid_o[ch]) @(negedge clk);
    e = shadow[ptrm[ch][7:0]];
    chk(host_rdata_o == e, tag, 32'(host_rdata_o), 32'(e));
    @(posedge clk); #1;
    host_rd_i = 1'b1;
    ptrm[ch] = ptrm[ch] + 1'b1;
    @(posedge clk); #1;
    host_rd_i = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    ptrm[0] = '0; ptrm[1] = '0;
    repeat (5) @(negedge clk);
    chk(!host_busy_o && host_valid_o == 2'b00, "R1 reset outputs", {host_busy_o, host_valid_o}, 32'd0);
    @(posedge clk); #1; rst_ni = 1'b1;
    @(negedge clk);
    chk(!host_busy_o && host_valid_o == 2'b00, "R1 outputs after reset", {host_busy_o, host_valid_o}, 32'd0);
    chk_ptr(0, "R1 R4 left pointer after reset");
    chk_ptr(1, "R1 R4 right pointer after reset");

    // R5 R12: interleaved streams
    set_ptr(0, 16'h0010);
    set_ptr(1, 16'h0040);
    write_word(0, 16'h1111);
    write_word(1, 16'h4444);
    write_word(0, 16'h2222);
    write_word(1, 16'h5555);
    write_word(0, 16'h3333);
    drain();
    chk(exp_q.size() == 0, "R5 all writes reached memory", 32'(exp_q.size()), 32'd0);
    chk_ptr(0, "R5 R12 left pointer advanced");
    chk_ptr(1, "R5 R12 right pointer advanced");

    // R6 R7: fill FIFO, dropped write, fetch waits for queued write
    wait_host_slot();
    set_ptr(0, 16'h0080);
    write_word(0, 16'hA001);
    write_word(0, 16'hA002);
    write_word(0, 16'hA003);
    write_word(0, 16'hA004);
    @(negedge clk);
    chk(host_busy_o, "R6 busy when FIFO full", 32'(host_busy_o), 32'd1);
    set_ptr(1, 16'h0081);
    write_drop(0, 16'hDEAD);
    chk_ptr(0, "R6 pointer unchanged by dropped write");
    read_word(1, "R7 fetch after queued write");
    drain();
    chk(exp_q.size() == 0, "R6 no extra write", 32'(exp_q.size()), 32'd0);

    // R8 R9: streamed reads
    set_ptr(0, 16'h0010);
    read_word(0, "R8 first read word");
    read_word(0, "R9 second read word");
    read_word(0, "R9 third read word");
    read_word(0, "R9 preload word");
    chk_ptr(0, "R9 pointer after reads");

    // R10: early read strobe ignored
    wait_host_slot();
    set_ptr(1, 16'h0020);
    @(posedge clk); #1;
    host_reg_i = REG_DAT_R_C; host_rd_i = 1'b1;
    @(posedge clk); #1;
    host_rd_i = 1'b0;
    chk_ptr(1, "R10 pointer unchanged by early read");
    read_word(1, "R10 word after ignored read");

    // R11: pointer reload while valid
    set_ptr(0, 16'h0030);
    @(negedge clk);
    while (!host_valid_o[0]) @(negedge clk);
    set_ptr(0, 16'h0050);
    @(negedge clk);
    chk(!host_valid_o[0], "R11 valid cleared by pointer load", 32'(host_valid_o[0]), 32'd0);
    read_word(0, "R11 word from new pointer");

    // R7: left fetch before right
    wait_host_slot();
    set_ptr(0, 16'h0060);
    set_ptr(1, 16'h0070);
    @(negedge clk);
    while (host_valid_o == 2'b00) @(negedge clk);
    chk(host_valid_o == 2'b01, "R7 left fetch first", 32'(host_valid_o), 32'd1);
    read_word(0, "R7 R12 left word");
    read_word(1, "R7 R12 right word");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [1:0] REG_DAT_R_C = 2'b11;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R3 watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule